// File: doc/BRIEF.md
# 24-Hour Minute Clock Digit Chain

This block keeps the time of day as four decimal digits, hours and minutes, on a 24-hour scale. It moves forward by one minute on every rising clock edge. The displayed time runs from 00:00 up to 23:59 and then returns to 00:00. Each digit is a 4-bit unsigned counter. A digit moves forward only on an edge where every lower digit is at its own limit. Because of this, a carry across several digits happens in a single edge.

The minute-units digit counts 0 to 9 and the minute-tens digit counts 0 to 5. The hour-tens digit counts 0 to 2. The hour-units digit has two limits: it counts to 9 while the hour-tens digit is 0 or 1, and only to 3 while the hour-tens digit is 2. Over one day its limits therefore run 9, 9, 3, and the chain wraps at 23:59. A synchronous active-high reset clears all four digits. Converting the digits for a display is left to the surrounding logic.

Top module: `minute_clock_chain`

## Requirements
- R1: While `rst` is high at a rising edge, all four digit outputs are 0 after that edge.
- R2: `min_units` increases by one on every rising edge that is not a reset, and goes from 9 to 0.
- R3: `min_tens` changes only on an edge where `min_units` is 9. On such an edge it increases by one, and goes from 5 to 0.
- R4: `hr_units` changes only on an edge where `min_units` is 9 and `min_tens` is 5. While `hr_tens` is 0 or 1 its limit is 9, so it goes from 9 to 0.
- R5: While `hr_tens` is 2, `hr_units` counts no higher than 3, and goes from 3 to 0.
- R6: `hr_tens` changes only on an edge where the three lower digits are all at their current limits (59 minutes, with hour units at 9 or 3). It goes from 2 to 0.
- R7: From 23:59, the next edge gives 00:00 on all four digits.
- R8: No digit ever exceeds its limit: minute units 9, minute tens 5, hour tens 2, and hour units 9, or 3 while hour tens is 2.
- R9: A carry across several digits completes within one edge. 09:59 is followed directly by 10:00, and 19:59 directly by 20:00.
- R10: A reset in the middle of the day overrides the advance on that edge, and counting resumes from 00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one minute |
| rst | input | 1 | Synchronous active-high clear of all digits |
| hr_tens | output | 4 | Hour tens digit, 0 to 2 |
| hr_units | output | 4 | Hour units digit, 0 to 9 (0 to 3 in hours 20-23) |
| min_tens | output | 4 | Minute tens digit, 0 to 5 |
| min_units | output | 4 | Minute units digit, 0 to 9 |

## Verification
The hardest situation to reach is the change of the hour-units limit. The limit drops to 3 only after the clock has passed 19:59 into 20:00. The rollover from 23:59 happens only after 1439 consecutive edges with no reset. There is no way to preload the digits, so the stimulus runs the clock through a whole day. At each edge it compares all four digits against a reference minute count. It then checks the 00:00 that follows 23:59, and applies a reset in the middle of the day to confirm that reset takes priority over an advance.

// File: rtl/clock_chain_pkg.sv
package clock_chain_pkg;
    localparam int DIGIT_W   = 4;
    localparam int NUM_DIGIT = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t count;
    } digit_state_t;
endpackage

// File: rtl/clock_carry_chain.sv
module clock_carry_chain
    import clock_chain_pkg::*;
#(
    parameter int N = NUM_DIGIT
) (
    input  logic [N-1:0] at_limit,
    output logic [N-1:0] advance
);
    // Lowest digit always advances; each higher digit advances only when
    // every lower digit is at its limit on the same edge.
    assign advance[0] = 1'b1;
    for (genvar i = 1; i < N; i++) begin : g_ripple
        assign advance[i] = advance[i-1] & at_limit[i-1];
    end
endmodule

// File: rtl/clock_digit_counter.sv
module clock_digit_counter
    import clock_chain_pkg::*;
#(
    parameter int MAX     = 9,
    parameter bit HAS_ALT = 1'b0,
    parameter int ALT_MAX = 9
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    input  logic   alt_sel,
    output digit_t value,
    output logic   at_limit
);
    localparam digit_t MAX_V = digit_t'(MAX);
    localparam digit_t ALT_V = digit_t'(ALT_MAX);

    digit_state_t state_d, state_q;
    digit_t       limit;

    assign limit    = (HAS_ALT && alt_sel) ? ALT_V : MAX_V;
    assign at_limit = (state_q.count >= limit);

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.count = '0;
        end else if (advance) begin
            if (state_q.count >= limit) begin
                state_d.count = '0;
            end else begin
                state_d.count = state_q.count + digit_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign value = state_q.count;
endmodule

// File: rtl/minute_clock_chain.sv
module minute_clock_chain
    import clock_chain_pkg::*;
#(
    parameter int MIN_U_MAX     = 9,
    parameter int MIN_T_MAX     = 5,
    parameter int HR_U_MAX      = 9,
    parameter int HR_U_LAST_MAX = 3,
    parameter int HR_T_MAX      = 2
) (
    input  logic       clk,
    input  logic       rst,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units
);
    localparam int     LIMITS [NUM_DIGIT] = '{MIN_U_MAX, MIN_T_MAX, HR_U_MAX, HR_T_MAX};
    localparam int     HR_U_IDX = 2;
    localparam int     HR_T_IDX = 3;
    localparam digit_t HR_T_TOP = digit_t'(HR_T_MAX);

    digit_t               digit_q [NUM_DIGIT];
    logic [NUM_DIGIT-1:0] at_limit;
    logic [NUM_DIGIT-1:0] advance;
    logic                 last_hours;

    // Hour-units switches to its short limit once hour-tens is at its top.
    assign last_hours = (digit_q[HR_T_IDX] == HR_T_TOP);

    clock_carry_chain #(.N(NUM_DIGIT)) i_carry (
        .at_limit (at_limit),
        .advance  (advance)
    );

    for (genvar i = 0; i < NUM_DIGIT; i++) begin : g_digit
        clock_digit_counter #(
            .MAX     (LIMITS[i]),
            .HAS_ALT (i == HR_U_IDX),
            .ALT_MAX (HR_U_LAST_MAX)
        ) i_digit (
            .clk      (clk),
            .rst      (rst),
            .advance  (advance[i]),
            .alt_sel  (last_hours),
            .value    (digit_q[i]),
            .at_limit (at_limit[i])
        );
    end

    assign min_units = digit_q[0];
    assign min_tens  = digit_q[1];
    assign hr_units  = digit_q[2];
    assign hr_tens   = digit_q[3];
endmodule

// File: rtl/clock_chain_checker.sv
module clock_chain_checker #(
    parameter int MIN_U_MAX     = 9,
    parameter int MIN_T_MAX     = 5,
    parameter int HR_U_MAX      = 9,
    parameter int HR_U_LAST_MAX = 3,
    parameter int HR_T_MAX      = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_units,
    input logic [3:0] min_tens,
    input logic [3:0] min_units
);
    localparam logic [3:0] MU = 4'(MIN_U_MAX);
    localparam logic [3:0] MT = 4'(MIN_T_MAX);
    localparam logic [3:0] HU = 4'(HR_U_MAX);
    localparam logic [3:0] HL = 4'(HR_U_LAST_MAX);
    localparam logic [3:0] HT = 4'(HR_T_MAX);

    logic [3:0] hu_lim;
    logic       minute_top;
    assign hu_lim     = (hr_tens == HT) ? HL : HU;
    assign minute_top = (min_units == MU) && (min_tens == MT);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (hr_tens == 4'd0 && hr_units == 4'd0 && min_tens == 4'd0 && min_units == 4'd0));

    assert_units_step_R2: assert property (@(posedge clk) disable iff (rst)
        (min_units != MU) |=> (min_units == $past(min_units) + 4'd1));

    assert_units_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (min_units == MU) |=> (min_units == 4'd0));

    assert_tens_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (min_units != MU) |=> $stable(min_tens));

    assert_hr_units_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !minute_top |=> $stable(hr_units));

    assert_hr_tens_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(minute_top && hr_units == hu_lim) |=> $stable(hr_tens));

    assert_day_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (minute_top && hr_units == HL && hr_tens == HT) |=>
        (hr_tens == 4'd0 && hr_units == 4'd0 && min_tens == 4'd0 && min_units == 4'd0));

    assert_range_R8: assert property (@(posedge clk) disable iff (rst)
        (min_units <= MU && min_tens <= MT && hr_tens <= HT && hr_units <= hu_lim));

    assert_last_hours_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (hr_tens == HT) |-> (hr_units <= HL));
endmodule

bind minute_clock_chain clock_chain_checker #(
    .MIN_U_MAX     (MIN_U_MAX),
    .MIN_T_MAX     (MIN_T_MAX),
    .HR_U_MAX      (HR_U_MAX),
    .HR_U_LAST_MAX (HR_U_LAST_MAX),
    .HR_T_MAX      (HR_T_MAX)
) i_chain_checker (
    .clk       (clk),
    .rst       (rst),
    .hr_tens   (hr_tens),
    .hr_units  (hr_units),
    .min_tens  (min_tens),
    .min_units (min_units)
);

// File: tb/test_minute_clock_chain.sv
module test_minute_clock_chain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] hr_tens, hr_units, min_tens, min_units;

    int checks = 0;
    int fails  = 0;
    int ref_min = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    minute_clock_chain i_minute_clock_chain (
        .clk       (clk),
        .rst       (rst),
        .hr_tens   (hr_tens),
        .hr_units  (hr_units),
        .min_tens  (min_tens),
        .min_units (min_units)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at ref minute %0d",
                     req, actual, expected, ref_min);
        end
    endtask

    // Compare all digits against the reference minute of day.
    task automatic compare_all();
        int h, m;
        h = ref_min / 60;
        m = ref_min % 60;
        check("R2 minute units", int'(min_units), m % 10);
        check("R3 minute tens",  int'(min_tens),  m / 10);
        if (h >= 20) check("R5 hour units", int'(hr_units), h % 10);
        else         check("R4 hour units", int'(hr_units), h % 10);
        check("R6 hour tens",    int'(hr_tens),   h / 10);
        checks++;
        if (min_units > 9 || min_tens > 5 || hr_tens > 2 ||
            (hr_tens == 2 && hr_units > 3) || hr_units > 9) begin
            fails++;
            $display("FAIL R8 range: actual %0d%0d:%0d%0d expected in range",
                     hr_tens, hr_units, min_tens, min_units);
        end
    endtask

    task automatic step();
        @(posedge clk);
        ref_min = (ref_min + 1) % 1440;
        @(negedge clk);
        compare_all();
    endtask

    task automatic check_time(input string req, input int hh, input int mm);
        check(req, int'(hr_tens) * 1000 + int'(hr_units) * 100 + int'(min_tens) * 10 + int'(min_units),
              hh * 100 + mm);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ref_min = 0;
        check_time("R1 reset state", 0, 0);
        rst = 1'b0;
    endtask

    task automatic test_full_day();
        for (int n = 0; n < 1439; n++) begin
            step();
            if (ref_min == 600)  check_time("R9 09:59 to 10:00", 10, 0);
            if (ref_min == 1200) check_time("R9 19:59 to 20:00", 20, 0);
            if (ref_min == 1439) check_time("R5 last minute 23:59", 23, 59);
        end
        step();
        check_time("R7 23:59 wraps to 00:00", 0, 0);
    endtask

    task automatic test_mid_reset();
        for (int n = 0; n < 137; n++) step();
        check_time("R10 before reset 02:17", 2, 17);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_min = 0;
        check_time("R10 reset overrides advance", 0, 0);
        rst = 1'b0;
        for (int n = 0; n < 3; n++) step();
        check_time("R10 resumes from zero", 0, 3);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_full_day();
        test_mid_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule